// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Vector Register

The block collects interrupt request pulses from a fixed set of sources and keeps each one as a posted bit until it is retired. A per-source mask turns posted bits into pending interrupts. While any interrupt is pending, the block raises a request line to the processor. A small register port gives software access to the masks, to the posted bits (which it can also force), and to a vector register. Reading the vector register returns the vector address of the most urgent pending interrupt. Writing the vector register clears every posted interrupt.

Source index k has vector address 4*(k+1). A lower index is more urgent, so vector 00h can only mean that nothing is pending. When the processor takes an interrupt, it pulses an acknowledge input. In that cycle the block shows the vector being serviced and retires that one source. Reads never retire anything.

Top module: `intc_vector_ctrl`

## Requirements
- R1: After reset all masks are 0 and all posted bits are 0, `irq_o` is low, and reads of every register return 00h.
- R2: A high `src_i[k]` in any cycle sets posted bit k at the next edge. Posted bits are read at address 2 (sources 0..7 on data bits 0..7) and address 3 (sources 8..11 on data bits 0..3).
- R3: A source is pending only when it is posted and its mask bit is 1, and `irq_o` is high exactly when some source is pending. A masked posted source stays posted and becomes pending as soon as it is unmasked.
- R4: A read of address 4 returns 4*(k+1), where k is the lowest-numbered pending source.
- R5: With nothing pending, the vector read and `ack_vec_o` both return 00h.
- R6: Reading any register changes no state.
- R7: A write of any data to address 4 clears every posted bit at the next edge.
- R8: A source pulse in the same cycle as a clear-all write stays posted.
- R9: Writing address 2 or 3 sets the posted bit of each source whose data bit is 1. Data bits that are 0 change nothing.
- R10: While `ack_i` is high, `ack_vec_o` shows the current vector, and only that source's posted bit is cleared at the next edge. A pulse from the same source in that cycle keeps it posted. An acknowledge with nothing pending changes nothing.
- R11: Mask bits are written at address 0 (sources 0..7) and address 1 (sources 8..11) and read back from the same addresses. Bits above the last source read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; `rdata_o` is 0 when low |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| src_i | input | 12 | Source request pulses |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Processor acknowledge |
| ack_vec_o | output | 8 | Vector of the current top interrupt |

## Verification
The bench looks for cases where the acknowledge clears the wrong source or more than one source: the next vector read would then skip a source, or it would return 00h too early. It fires a source pulse in the same cycle as a clear-all write, and in the same cycle as an acknowledge of that source. A design that lets the clear win would lose the event, and its posted readback would come up short. It also posts sources while they are masked and then unmasks them. A design that gates posting with the mask would never raise `irq_o` after the unmask. Repeated vector reads show whether a read retires an interrupt.

// File: rtl/intc_pkg.sv
package intc_pkg;
  function automatic int unsigned calc_regs(int unsigned n, int unsigned w);
    return (n + w - 1) / w;
  endfunction
  function automatic int unsigned calc_idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/intc_post_bank.sv
module intc_post_bank #(
  parameter int unsigned NUM_SRC = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_all_i,
  input  logic [NUM_SRC-1:0] ack_clr_i,
  output logic [NUM_SRC-1:0] posted_o
);
  logic [NUM_SRC-1:0] posted_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // set wins over any clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) posted_q[i] <= 1'b0;
      else         posted_q[i] <= set_i[i] | (posted_q[i] & ~clr_all_i & ~ack_clr_i[i]);
    end
  end

  assign posted_o = posted_q;

  // R7
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (posted_q & ~$past(set_i)) == '0);
  // R8
  set_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (($past(set_i) & ~posted_q) == '0));
  // R10
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_clr_i != '0) |=> ((posted_q & $past(ack_clr_i & ~set_i)) == '0));
  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_all_i && ack_clr_i == '0) |=> (($past(posted_q) & ~posted_q) == '0));
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [VEC_W-1:0]   vec_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;
  assign vec_o   = valid_o ? VEC_W'((int'(idx_o) + 1) * VEC_STEP) : '0;

  logic [NUM_SRC-1:0] below_mask;
  assign below_mask = (NUM_SRC'(1) << idx_o) - NUM_SRC'(1);

  // R4
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (req_i[idx_o] && (req_i & below_mask) == '0));
  // R5
  zero_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> vec_o == '0);
endmodule

// File: rtl/intc_regif.sv
module intc_regif #(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NUM_REG = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] posted_i,
  input  logic [DATA_W-1:0]  vec_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] force_o,
  output logic               clr_all_o
);
  localparam int unsigned PAD_W    = NUM_REG * DATA_W;
  localparam int unsigned ADDR_VEC = 2 * NUM_REG;

  logic [NUM_SRC-1:0] mask_q;
  logic [PAD_W-1:0]   mask_pad, post_pad;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned REG = i / DATA_W;
    localparam int unsigned BIT = i % DATA_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[i] <= 1'b0;
      else if (wr_en_i && addr_i == ADDR_W'(REG)) mask_q[i] <= wdata_i[BIT];
    end
    assign force_o[i] = wr_en_i && addr_i == ADDR_W'(NUM_REG + REG) && wdata_i[BIT];
  end

  assign clr_all_o = wr_en_i && addr_i == ADDR_W'(ADDR_VEC);
  assign mask_o    = mask_q;
  assign mask_pad  = PAD_W'(mask_q);
  assign post_pad  = PAD_W'(posted_i);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (addr_i == ADDR_W'(r))           rdata_o = mask_pad[r*DATA_W +: DATA_W];
        if (addr_i == ADDR_W'(NUM_REG + r)) rdata_o = post_pad[r*DATA_W +: DATA_W];
      end
      if (addr_i == ADDR_W'(ADDR_VEC)) rdata_o = vec_i;
    end
  end

  // R11
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/intc_vector_ctrl.sv
module intc_vector_ctrl #(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  input  logic               ack_i,
  output logic [DATA_W-1:0]  ack_vec_o
);
  import intc_pkg::*;
  localparam int unsigned NUM_REG = calc_regs(NUM_SRC, DATA_W);
  localparam int unsigned IDX_W   = calc_idx_w(NUM_SRC);

  logic [NUM_SRC-1:0] posted, mask, force_set, ack_clr, pending;
  logic               clr_all, top_valid;
  logic [IDX_W-1:0]   top_idx;
  logic [DATA_W-1:0]  top_vec;

  intc_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_regif (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o,
    .posted_i(posted), .vec_i(top_vec), .mask_o(mask), .force_o(force_set), .clr_all_o(clr_all)
  );

  intc_post_bank #(.NUM_SRC(NUM_SRC)) u_post (
    .clk_i, .rst_ni, .set_i(src_i | force_set), .clr_all_i(clr_all),
    .ack_clr_i(ack_clr), .posted_o(posted)
  );

  assign pending = posted & mask;

  intc_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(DATA_W), .VEC_STEP(VEC_STEP)) u_enc (
    .clk_i, .rst_ni, .req_i(pending), .valid_o(top_valid), .idx_o(top_idx), .vec_o(top_vec)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign ack_clr[i] = ack_i && top_valid && top_idx == IDX_W'(i);
  end

  assign irq_o     = |pending;
  assign ack_vec_o = top_vec;

  // R3
  irq_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ack_vec_o != '0));
  // R10
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_clr) && (ack_i || ack_clr == '0));
endmodule

// File: tb/intc_vector_ctrl_test.sv
module intc_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0]  wdata = '0;
  logic [11:0] src = '0;
  logic [7:0]  rdata, ack_vec;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  bit m_post[12];
  bit m_mask[12];

  always #10 clk = ~clk;

  intc_vector_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq),
    .ack_i(ack), .ack_vec_o(ack_vec)
  );

  function automatic int top_src();
    for (int k = 0; k < 12; k++) if (m_post[k] && m_mask[k]) return k;
    return -1;
  endfunction

  function automatic int exp_vec();
    int t = top_src();
    return (t < 0) ? 0 : 4 * (t + 1);
  endfunction

  function automatic int byte_of(input int sel, input int base);
    int v = 0;
    for (int b = 0; b < 8; b++) begin
      int k = base * 8 + b;
      if (k < 12) v += ((sel == 0) ? int'(m_mask[k]) : int'(m_post[k])) << b;
    end
    return v;
  endfunction

  function automatic int exp_rdata();
    if (!rd) return 0;
    case (addr)
      3'd0: return byte_of(0, 0);
      3'd1: return byte_of(0, 1);
      3'd2: return byte_of(1, 0);
      3'd3: return byte_of(1, 1);
      3'd4: return exp_vec();
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input logic w, input logic r, input logic [7:0] d,
                     input logic [11:0] s, input logic k, input string req);
    int t;
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d; src = s; ack = k;
    #2;
    chk(req, "irq", int'(irq), (top_src() >= 0) ? 1 : 0);
    chk(req, "ack_vec", int'(ack_vec), exp_vec());
    chk(req, "rdata", int'(rdata), exp_rdata());
    @(posedge clk);
    t = top_src();
    if (w && a == 3'd0) for (int b = 0; b < 8; b++) m_mask[b] = d[b];
    if (w && a == 3'd1) for (int b = 0; b < 4; b++) m_mask[8 + b] = d[b];
    if (w && a == 3'd4) for (int q = 0; q < 12; q++) m_post[q] = 0;
    if (k && t >= 0) m_post[t] = 0;
    for (int q = 0; q < 12; q++) if (s[q]) m_post[q] = 1;
    if (w && a == 3'd2) for (int b = 0; b < 8; b++) if (d[b]) m_post[b] = 1;
    if (w && a == 3'd3) for (int b = 0; b < 4; b++) if (d[b]) m_post[8 + b] = 1;
  endtask

  task automatic rdv(input logic [2:0] a, input string req);
    cyc(a, 1'b0, 1'b1, 8'h00, 12'h000, 1'b0, req);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < 12; q++) begin m_post[q] = 0; m_mask[q] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rdv(3'd4, "R1"); rdv(3'd0, "R1"); rdv(3'd1, "R1"); rdv(3'd2, "R1"); rdv(3'd3, "R1");
    // R2 posting while masked, R3 no irq yet
    cyc(3'd0, 1'b0, 1'b0, 8'h00, 12'h020, 1'b0, "R2");
    rdv(3'd2, "R2"); rdv(3'd4, "R3");
    // R3 unmask -> pending, R4 vector 18h
    cyc(3'd0, 1'b1, 1'b0, 8'hFF, 12'h000, 1'b0, "R3");
    rdv(3'd4, "R4");
    cyc(3'd0, 1'b0, 1'b0, 8'h00, 12'h004, 1'b0, "R4");
    // R6 repeated reads leave state alone
    rdv(3'd4, "R6"); rdv(3'd4, "R6"); rdv(3'd2, "R6");
    // R10 ack retires only source 2
    cyc(3'd4, 1'b0, 1'b1, 8'h00, 12'h000, 1'b1, "R10");
    rdv(3'd4, "R10"); rdv(3'd2, "R10");
    // R7 clear-all with arbitrary data
    cyc(3'd4, 1'b1, 1'b0, 8'h5A, 12'h000, 1'b0, "R7");
    rdv(3'd4, "R7"); rdv(3'd2, "R7");
    // R3 masked high sources, then unmask
    cyc(3'd0, 1'b0, 1'b0, 8'h00, 12'h200, 1'b0, "R3");
    rdv(3'd4, "R3"); rdv(3'd3, "R2");
    cyc(3'd1, 1'b1, 1'b0, 8'hFF, 12'h000, 1'b0, "R11");
    rdv(3'd1, "R11"); rdv(3'd4, "R4");
    // R8 pulse during clear-all survives
    cyc(3'd4, 1'b1, 1'b0, 8'h00, 12'h800, 1'b0, "R8");
    rdv(3'd3, "R8"); rdv(3'd4, "R8");
    // R9 force-post and zero write
    cyc(3'd2, 1'b1, 1'b0, 8'h81, 12'h000, 1'b0, "R9");
    rdv(3'd2, "R9"); rdv(3'd4, "R9");
    cyc(3'd3, 1'b1, 1'b0, 8'h00, 12'h000, 1'b0, "R9");
    rdv(3'd3, "R9");
    // R10 ack with same-source pulse keeps it posted
    cyc(3'd4, 1'b0, 1'b1, 8'h00, 12'h001, 1'b1, "R10");
    rdv(3'd2, "R10");
    // R10 ack with nothing pending, R5 zero vector
    cyc(3'd4, 1'b1, 1'b0, 8'h00, 12'h000, 1'b0, "R7");
    cyc(3'd4, 1'b0, 1'b1, 8'h00, 12'h000, 1'b1, "R10");
    rdv(3'd4, "R5");
    // R11 mask readback and padding
    cyc(3'd0, 1'b1, 1'b0, 8'hA5, 12'h000, 1'b0, "R11");
    rdv(3'd0, "R11");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 19);
      logic [2:0] a = 3'($urandom_range(0, 5));
      logic [11:0] s = ($urandom_range(0, 2) == 0) ? 12'($urandom) : 12'h000;
      cyc(a, op == 0 || (op == 1 && a != 3'd4), op > 3, 8'($urandom), s, op == 2 || op == 3, "R4");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule